// File: doc/BRIEF.md
# Key Press Settle Filter

This block sits behind a keypad scanner and turns its raw "some row is down" flag into one clean event per keystroke. Contacts chatter when a key is pressed. The filter therefore waits until the flag has been seen high on a fixed number of consecutive clock edges before it reports the press. It then raises its output for exactly one clock cycle, which the downstream decoder uses as its capture strobe.

Internally a four-state machine (idle, counting, strobe on, strobe off) works together with a settle counter. A press that drops out before the window fills is discarded. A key that stays down produces a single strobe however long it is held. Another strobe is possible only after the flag has been sampled low while the machine is idle. The block runs on the scanner's slow clock and is reset synchronously.

Top module: `press_debouncer`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle shows `key_valid` low, and any count in progress is discarded. Counting starts afresh from the first press sampled after reset.
- R2: Starting from the armed idle state, if `key_down` is sampled high on `SETTLE_CYCLES` consecutive rising edges, `key_valid` is high during the cycle that follows the last of those edges.
- R3: `key_valid` is never high in two consecutive cycles.
- R4: If `key_down` is sampled low before the settle window is full, no strobe is produced and the count is discarded. A later press must again be seen high on `SETTLE_CYCLES` consecutive edges.
- R5: A key held for any length of time gives exactly one strobe.
- R6: After a strobe, a new press is accepted only once `key_down` has been sampled low while the machine is idle. A low sample taken while the strobe is still on or being cleared does not re-arm it. One idle low sample is sufficient.
- R7: The settle length is the parameter `SETTLE_CYCLES` (default 10, minimum 2). Strobe latency follows it exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow scan clock |
| rst | input | 1 | Synchronous reset, active high |
| key_down | input | 1 | Raw row-pressed flag from the scanner, active high |
| key_valid | output | 1 | One-cycle strobe for an accepted press |

## Verification
The hardest case to reach from the ports is a key that is released only while the strobe is on or being cleared, and then pressed again at once. Because the machine never sees a low sample while it is idle, it must stay unarmed. The bench builds this case by releasing `key_down` for the one edge that moves the machine from strobe-on to strobe-off. It then holds the key well beyond a full window and expects silence. A sweep of press lengths from zero to beyond the window, with the default settle length, covers the abort and accept boundary on both sides.

// File: rtl/debounce_pkg.sv
package debounce_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COUNT  = 2'd1,
    ST_STROBE = 2'd2,
    ST_DONE   = 2'd3
  } db_state_e;

  // True when one more high sample completes a window of 'limit' samples.
  function automatic logic window_full(int unsigned seen, int unsigned limit);
    return (seen + 1) == limit;
  endfunction

endpackage

// File: rtl/settle_counter.sv
module settle_counter
  import debounce_pkg::*;
#(
  parameter int unsigned LIMIT = 10,
  parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [CW-1:0] seen,
  output logic          full
);

  assign full = step && window_full(32'(seen), LIMIT);

  always_ff @(posedge clk) begin
    if (rst || !step || full) seen <= '0;
    else                      seen <= seen + 1'b1;
  end

  // R2: the counter never holds a full window; it wraps when the window completes
  assert_count_bounded_R2: assert property (@(posedge clk) disable iff (rst)
    32'(seen) < LIMIT);

  // R4: a cycle without a step leaves the counter at zero
  assert_count_cleared_R4: assert property (@(posedge clk) disable iff (rst)
    !step |=> seen == '0);

endmodule

// File: rtl/debounce_fsm.sv
module debounce_fsm
  import debounce_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pressed,
  input  logic      full,
  output logic      step,
  output logic      strobe,
  output db_state_e state_o,
  output logic      armed_o
);

  db_state_e state, state_nx;
  logic      armed;
  logic      accept;

  assign accept  = (state == ST_IDLE) && pressed && armed;
  assign step    = accept || ((state == ST_COUNT) && pressed);
  assign strobe  = (state == ST_STROBE);
  assign state_o = state;
  assign armed_o = armed;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (accept) state_nx = ST_COUNT;
      ST_COUNT:  if (!pressed) state_nx = ST_IDLE;
                 else if (full) state_nx = ST_STROBE;
      ST_STROBE: state_nx = ST_DONE;
      ST_DONE:   state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      armed <= 1'b1;
    end else begin
      state <= state_nx;
      if (state == ST_DONE)                  armed <= 1'b0;
      else if (state == ST_IDLE && !pressed) armed <= 1'b1;
    end
  end

  // R1: reset returns the machine to idle with the strobe off
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE) && !strobe);

  // R3: the strobe lasts a single cycle
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

  // R2: the strobe only follows a completed window with the key still down
  assert_strobe_after_window_R2: assert property (@(posedge clk) disable iff (rst)
    strobe |-> $past(pressed) && $past(full));

  // R4: a low sample while counting aborts to idle
  assert_abort_to_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_COUNT && !pressed) |=> state == ST_IDLE);

  // R5 R6: leaving strobe-off always lands in an unarmed idle
  assert_disarm_after_done_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state == ST_IDLE) && !armed);

endmodule

// File: rtl/press_debouncer.sv
module press_debouncer
  import debounce_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic key_down,
  output logic key_valid
);

  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);

  logic          cnt_step;
  logic          cnt_full;
  logic [CW-1:0] cnt_seen;
  db_state_e     fsm_state;
  logic          fsm_armed;

  // R7: the window must span at least two samples
  initial begin
    assert_settle_min_R7: assert (SETTLE_CYCLES >= 2);
  end

  settle_counter #(.LIMIT(SETTLE_CYCLES), .CW(CW)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .step (cnt_step),
    .seen (cnt_seen),
    .full (cnt_full)
  );

  debounce_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .pressed (key_down),
    .full    (cnt_full),
    .step    (cnt_step),
    .strobe  (key_valid),
    .state_o (fsm_state),
    .armed_o (fsm_armed)
  );

  // R5: a strobe is never directly followed by counting, even with the key held
  assert_no_count_after_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> fsm_state == ST_DONE);

  // R6: an unarmed idle never starts counting
  assert_unarmed_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_IDLE && !fsm_armed) |=> fsm_state == ST_IDLE);

endmodule

// File: tb/press_debouncer_tb.sv
module press_debouncer_tb;
  localparam int N = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_down = 1'b0;
  logic key_valid;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  press_debouncer #(.SETTLE_CYCLES(N)) u_dut (
    .clk(clk), .rst(rst), .key_down(key_down), .key_valid(key_valid)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: key_valid=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // one edge with the given input; sample after it
  task automatic tick(input logic level, input string req, input logic exp);
    key_down = level;
    @(posedge clk);
    @(negedge clk);
    check(req, key_valid, exp);
  endtask

  // press for len edges from armed idle, then 3 low edges
  task automatic burst(input int len, input string req);
    for (int k = 1; k <= len; k++) tick(1'b1, req, k == N);
    for (int g = 0; g < 3; g++) tick(1'b0, req, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    tick(1'b0, "R1", 1'b0);
    tick(1'b1, "R1", 1'b0);
    rst = 1'b0;
    // R2 R4 R7: sweep press lengths around the window
    for (int len = 0; len <= N + 4; len++) burst(len, len < N ? "R4" : "R2");
    // R4: abort then immediate full press counts from zero
    for (int k = 0; k < N - 1; k++) tick(1'b1, "R4", 1'b0);
    tick(1'b0, "R4", 1'b0);
    burst(N, "R4");
    // R5: long hold gives one strobe
    for (int k = 1; k <= 4 * N; k++) tick(1'b1, "R5", k == N);
    // R6: one idle low sample re-arms
    tick(1'b0, "R6", 1'b0);
    burst(N, "R6");
    // R6: release only during strobe-off does not re-arm
    for (int k = 1; k <= N; k++) tick(1'b1, "R6", k == N);
    tick(1'b0, "R6", 1'b0);
    for (int k = 0; k < 2 * N; k++) tick(1'b1, "R6", 1'b0);
    tick(1'b0, "R6", 1'b0);
    // R1: reset mid-count discards progress
    for (int k = 0; k < N - 2; k++) tick(1'b1, "R1", 1'b0);
    rst = 1'b1;
    tick(1'b1, "R1", 1'b0);
    rst = 1'b0;
    tick(1'b0, "R1", 1'b0);
    for (int k = 1; k <= N + 1; k++) tick(1'b1, "R1", k == N);
    // R3: no two adjacent strobes over a toggling pattern
    for (int k = 0; k < 40; k++) tick(k % 7 != 6, "R3", (k % 7) == N - 1);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule